// File: doc/BRIEF.md
# Serial Port Period Timer

A general-purpose timer that sits next to one direction of a serial port. A counter advances on a timer clock and is compared with a period register. The timer clock is either an internal source running at half the system clock rate, or an external pin that the block synchronizes before it uses it. Each time the counter wraps past the period value, a period event occurs. A status flag then shows the event in one of two ways: as a single-cycle pulse, or as a square wave with 50% duty cycle that toggles on every event. An interrupt pulse marks every rising edge of the status flag.

Software starts or restarts the count with a self-clearing go bit. The bit stays set until the next timer-clock edge and clears on that edge. A run control holds the counter when it is low. It also holds the half-rate prescaler, so counting later resumes in the same phase. The counter and period registers can be written at any time and are always readable. The status flag cannot be written.

Top module: `tmr_period_timer`

## Requirements
- R1: Reset is asynchronous and active low. It clears the counter, the period, the go bit, the status flag and the interrupt. Reset takes effect even while run_i is 0.
- R2: With src_int_i = 1 and run_i = 1, the counter advances once every two clock cycles. A go write clears the prescaler, so the first advance follows on the second run cycle after the go write.
- R3: With src_int_i = 0, the counter advances once for each rising edge of ext_clk_i. The edge passes through two synchronizer flops, so the count changes on the third clock edge after the pin rises. Each level of the pin must be held for at least two clock cycles.
- R4: Writing go with go_wdata_i = 1 while run_i = 1 sets go_o and shows a count of 0 in the next cycle. While go is set, the counter stays at 0. On the next timer tick the counter advances from 0 and go_o clears. A go write with go_wdata_i = 0 changes nothing.
- R5: On a timer tick with a nonzero period, the counter goes to 0 and a period event occurs if the count is equal to or greater than the period. Otherwise the counter increases by 1. A full cycle therefore takes period+1 ticks.
- R6: While the period is 0 and run_i = 1, the counter reads 0 and no period event occurs.
- R7: While run_i = 0, the counter and the prescaler keep their values. Internal counting then resumes in the same two-cycle phase.
- R8: In pulse mode (clk_mode_i = 0), status_o is high for exactly one cycle per period event. That cycle is the first cycle in which the counter shows 0 after the wrap.
- R9: In clock mode (clk_mode_i = 1), status_o toggles on every period event. With the internal source it stays at each level for 2*(period+1) cycles.
- R10: irq_o is high for one cycle, in the first cycle in which status_o is 1 after having been 0.
- R11: A counter or period write shows its value in the next cycle. A counter write takes priority over a timer tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External timer clock pin, asynchronous |
| src_int_i | input | 1 | 1: internal half-rate source, 0: external pin |
| clk_mode_i | input | 1 | 1: clock (toggle) mode, 0: pulse mode |
| run_i | input | 1 | 1: timer runs, 0: counter and prescaler held |
| go_wr_i | input | 1 | Write strobe for the go bit |
| go_wdata_i | input | 1 | Go bit write data; only 1 acts |
| cnt_wr_i | input | 1 | Counter write strobe |
| cnt_wdata_i | input | CNT_W | Counter write data |
| per_wr_i | input | 1 | Period write strobe |
| per_wdata_i | input | CNT_W | Period write data |
| count_o | output | CNT_W | Current counter value |
| period_o | output | CNT_W | Current period value |
| go_o | output | 1 | Go bit, pending restart |
| status_o | output | 1 | Timer status flag |
| irq_o | output | 1 | One-cycle interrupt on status rising edge |

## Verification
Each register lies one clock edge behind the input that feeds it. A go write therefore shows go_o = 1 and a zero count in the next cycle. With the internal source, the count advances on every second run cycle after that. The status flag and the interrupt change on the same edge as the wrapping count. An external pin edge reaches the count on the third clock edge. Inputs are driven on the falling clock edge and outputs are sampled on the next falling edge. A bench model counts the run cycles since the go write and, from that count alone, predicts the counter, go, status and interrupt for every cycle while run_i is toggled at random. External-source intervals are measured between status rising edges, so the synchronizer latency cancels.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_INT = 1'b1
    } tmr_src_e;

    typedef enum logic {
        MODE_PULSE = 1'b0,
        MODE_CLOCK = 1'b1
    } tmr_mode_e;

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  tmr_src_e src_i,
    input  logic     run_i,
    input  logic     pre_clr_i,
    input  logic     ext_clk_i,
    output logic     tick_o
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] sync;
        logic               pre;
    } tg_state_t;

    tg_state_t s_d, s_q;
    logic      ext_rise;

    // last synchronized stage high, one-older copy low
    assign ext_rise = s_q.sync[SYNC_STAGES-1] & ~s_q.sync[SYNC_STAGES];

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[CHAIN_W-2:0], ext_clk_i};
        if (pre_clr_i) begin
            s_d.pre = 1'b0;
        end else if (run_i && src_i == SRC_INT) begin
            s_d.pre = ~s_q.pre;
        end
        tick_o = run_i & ((src_i == SRC_INT) ? s_q.pre : ext_rise);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/tmr_core.sv
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  tmr_mode_e        mode_i,
    input  logic             go_set_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             per_wr_i,
    input  logic [CNT_W-1:0] per_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] period_o,
    output logic             go_o,
    output logic             status_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] ZERO = '0;
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [CNT_W-1:0] period;
        logic             go;
        logic             status;
        logic             irq;
    } core_state_t;

    core_state_t      s_d, s_q;
    logic             event_w;
    logic [CNT_W-1:0] base;

    always_comb begin
        s_d     = s_q;
        event_w = 1'b0;
        base    = s_q.go ? ZERO : s_q.count;

        if (go_set_i) begin
            s_d.go = 1'b1;
            if (run_i) begin
                s_d.count = ZERO;
            end
        end else if (tick_i) begin
            s_d.go = 1'b0;
            if (s_q.period == ZERO) begin
                s_d.count = ZERO;
            end else if (base >= s_q.period) begin
                s_d.count = ZERO;
                event_w   = 1'b1;
            end else begin
                s_d.count = base + ONE;
            end
        end else if (run_i && (s_q.go || s_q.period == ZERO)) begin
            s_d.count = ZERO;
        end

        if (cnt_wr_i) begin
            s_d.count = cnt_wdata_i;
        end
        if (per_wr_i) begin
            s_d.period = per_wdata_i;
        end

        s_d.status = (mode_i == MODE_CLOCK) ? (s_q.status ^ event_w) : event_w;
        s_d.irq    = s_d.status & ~s_q.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count_o  = s_q.count;
    assign period_o = s_q.period;
    assign go_o     = s_q.go;
    assign status_o = s_q.status;
    assign irq_o    = s_q.irq;

endmodule

// File: rtl/tmr_period_timer.sv
module tmr_period_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic             src_int_i,
    input  logic             clk_mode_i,
    input  logic             run_i,
    input  logic             go_wr_i,
    input  logic             go_wdata_i,
    input  logic             cnt_wr_i,
    input  logic [CNT_W-1:0] cnt_wdata_i,
    input  logic             per_wr_i,
    input  logic [CNT_W-1:0] per_wdata_i,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] period_o,
    output logic             go_o,
    output logic             status_o,
    output logic             irq_o
);

    logic go_set;
    logic tick;

    assign go_set = go_wr_i & go_wdata_i;

    tmr_tick_gen #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_i    (tmr_src_e'(src_int_i)),
        .run_i    (run_i),
        .pre_clr_i(go_set),
        .ext_clk_i(ext_clk_i),
        .tick_o   (tick)
    );

    tmr_core #(
        .CNT_W(CNT_W)
    ) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .run_i      (run_i),
        .mode_i     (tmr_mode_e'(clk_mode_i)),
        .go_set_i   (go_set),
        .cnt_wr_i   (cnt_wr_i),
        .cnt_wdata_i(cnt_wdata_i),
        .per_wr_i   (per_wr_i),
        .per_wdata_i(per_wdata_i),
        .count_o    (count_o),
        .period_o   (period_o),
        .go_o       (go_o),
        .status_o   (status_o),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/tmr_period_timer_chk.sv
module tmr_period_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_mode_i,
    input logic             run_i,
    input logic             cnt_wr_i,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] period_o,
    input logic             go_o,
    input logic             status_o,
    input logic             irq_o
);

    // R7: a held timer keeps its count
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !cnt_wr_i) |=> $stable(count_o));

    // R6: zero period keeps the count at zero
    p_zero_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && period_o == '0 && !cnt_wr_i) |=> (count_o == '0));

    // R10: interrupt only in the first cycle of a high status
    p_irq_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o && !$past(status_o)));

    // R8: pulse mode status lasts a single cycle
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !clk_mode_i) |=> !status_o);

    // R4: go clears on the first advance from zero
    p_go_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go_o) && !$past(cnt_wr_i)) |-> (count_o <= CNT_W'(1)));

endmodule

bind tmr_period_timer tmr_period_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_mode_i(clk_mode_i),
    .run_i     (run_i),
    .cnt_wr_i  (cnt_wr_i),
    .count_o   (count_o),
    .period_o  (period_o),
    .go_o      (go_o),
    .status_o  (status_o),
    .irq_o     (irq_o)
);

// File: tb/tb_tmr_period_timer.sv
module tb_tmr_period_timer;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ext_clk_i = 1'b0;
    logic             src_int_i = 1'b1;
    logic             clk_mode_i = 1'b0;
    logic             run_i = 1'b0;
    logic             go_wr_i = 1'b0;
    logic             go_wdata_i = 1'b0;
    logic             cnt_wr_i = 1'b0;
    logic [CNT_W-1:0] cnt_wdata_i = '0;
    logic             per_wr_i = 1'b0;
    logic [CNT_W-1:0] per_wdata_i = '0;
    logic [CNT_W-1:0] count_o;
    logic [CNT_W-1:0] period_o;
    logic             go_o;
    logic             status_o;
    logic             irq_o;

    int  checks = 0;
    int  errors = 0;
    int  cyc = 0;
    bit  done = 1'b0;
    bit  ext_en = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    tmr_period_timer #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ext_clk_i(ext_clk_i), .src_int_i(src_int_i),
        .clk_mode_i(clk_mode_i), .run_i(run_i), .go_wr_i(go_wr_i),
        .go_wdata_i(go_wdata_i), .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
        .per_wr_i(per_wr_i), .per_wdata_i(per_wdata_i), .count_o(count_o),
        .period_o(period_o), .go_o(go_o), .status_o(status_o), .irq_o(irq_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // expected count after n run cycles since a go write (R2, R5)
    function automatic int exp_count(input int n, input int p);
        return (n / 2) % (p + 1);
    endfunction

    // number of period events after n run cycles (R5, R9)
    function automatic int exp_events(input int n, input int p);
        return (n / 2) / (p + 1);
    endfunction

    // external pin: 3 cycles high, 3 cycles low
    initial begin
        forever begin
            @(negedge clk);
            if (ext_en) begin
                ext_clk_i = 1'b1;
                repeat (3) @(negedge clk);
                ext_clk_i = 1'b0;
                repeat (2) @(negedge clk);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int p, n, start, ev, last_rise, ival, bad;
        bit tick_last, es, prev_es, ok;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 count", count_o, 0);
        chk("R1 period", period_o, 0);
        chk("R1 go", go_o, 0);
        chk("R1 status", status_o, 0);
        chk("R1 irq", irq_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: writes while held, then R7 hold, then R5 wrap
        cnt_wr_i = 1'b1; cnt_wdata_i = 16'd7;
        per_wr_i = 1'b1; per_wdata_i = 16'd9;
        @(negedge clk);
        cnt_wr_i = 1'b0; per_wr_i = 1'b0;
        chk("R11 count write", count_o, 7);
        chk("R11 period write", period_o, 9);
        repeat (5) @(negedge clk);
        chk("R7 held count", count_o, 7);
        run_i = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 resume two ticks", count_o, 9);
        repeat (2) @(negedge clk);
        chk("R5 wrap to zero", count_o, 0);

        // random periods and modes against the run-cycle model
        void'($urandom(32'h5eed_1234));
        for (int it = 0; it < 8; it++) begin
            p = $urandom_range(1, 9);
            run_i = 1'b0;
            per_wr_i = 1'b1; per_wdata_i = CNT_W'(p);
            clk_mode_i = it[0];
            @(negedge clk);
            per_wr_i = 1'b0;
            run_i = 1'b1; go_wr_i = 1'b1; go_wdata_i = 1'b1;
            @(negedge clk);
            go_wr_i = 1'b0; go_wdata_i = 1'b0;
            n = 0; tick_last = 1'b0;
            start = status_o;
            chk("R4 go set", go_o, 1);
            chk("R4 count zero", count_o, 0);
            prev_es = start[0];
            bad = 0;
            for (int c = 0; c < 160; c++) begin
                ev = exp_events(n, p);
                if (clk_mode_i) es = start[0] ^ ev[0];
                else es = tick_last && (exp_count(n, p) == 0);
                ok = (count_o == CNT_W'(exp_count(n, p))) && (go_o == (n < 2))
                     && (status_o == es) && (irq_o == (es && !prev_es));
                if (!ok && bad == 0) begin
                    bad = 1;
                    chk("R2 R4 R8 R9 R10 count", count_o, exp_count(n, p));
                    chk("R8 R9 status", status_o, es);
                    chk("R10 irq", irq_o, es && !prev_es);
                    chk("R4 go", go_o, n < 2);
                end
                prev_es = es;
                run_i = ($urandom_range(0, 3) != 0);
                go_wr_i = ($urandom_range(0, 7) == 0);
                go_wdata_i = 1'b0;
                @(posedge clk);
                if (run_i) begin
                    n++;
                    tick_last = (n % 2 == 0);
                end else begin
                    tick_last = 1'b0;
                end
                @(negedge clk);
            end
            go_wr_i = 1'b0;
            chk("R2 R7 model run", bad, 0);
        end

        // R6: zero period
        run_i = 1'b1; clk_mode_i = 1'b0;
        per_wr_i = 1'b1; per_wdata_i = '0;
        @(negedge clk);
        per_wr_i = 1'b0;
        go_wr_i = 1'b1; go_wdata_i = 1'b1;
        @(negedge clk);
        go_wr_i = 1'b0; go_wdata_i = 1'b0;
        bad = 0;
        for (int c = 0; c < 30; c++) begin
            if (count_o != 0 || status_o) bad++;
            @(negedge clk);
        end
        chk("R6 zero period idle", bad, 0);

        // R3: external source interval, pulse mode, period 3 -> 4 ticks * 6 cycles
        src_int_i = 1'b0;
        per_wr_i = 1'b1; per_wdata_i = 16'd3;
        @(negedge clk);
        per_wr_i = 1'b0;
        ext_en = 1'b1;
        last_rise = -1;
        for (int k = 0; k < 3; k++) begin
            int guard = 0;
            while (!status_o && guard < 200) begin
                @(negedge clk);
                guard++;
            end
            if (last_rise >= 0) begin
                ival = cyc - last_rise;
                chk("R3 external interval", ival, 24);
            end
            last_rise = cyc;
            @(negedge clk);
        end

        // R1: reset dominates hold
        run_i = 1'b0;
        cnt_wr_i = 1'b1; cnt_wdata_i = 16'd2;
        @(negedge clk);
        cnt_wr_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset while held", count_o, 0);
        chk("R1 reset period", period_o, 0);
        rst_n = 1'b1;
        ext_en = 1'b0;
        @(negedge clk);

        finish_run();
    end

endmodule